// File: doc/BRIEF.md
# Paged Register Write Sequencer

This block turns a stream of register-write records into commands for an I2C master that configures a clock-synthesizer-style device with paged register addressing. Each record carries an operation code, a 16-bit register address and an 8-bit value. The high address byte selects a page and the low byte an offset within it. The block remembers which page it last selected and which address the device's auto-increment pointer will hit next. It sends a page-select write only when the page changes, and it opens a new addressed transfer only when the address breaks sequence. A run of consecutive registers therefore goes out as one burst.

Two channels carry the output, each with a valid/ready handshake. The command channel holds a 12-bit word: the 7-bit device address and the start, read, write, write-multiple and stop flags. The data channel holds one byte for every write command. A start pulse opens a session and clears all tracking. An end-of-list record closes the session with a stop-only command. A delay record inserts a programmable wait, for example the long pause a device needs after its preamble writes before the main register list.

Top module: `paged_reg_writer`

## Requirements
- R1: For a write record whose page (address bits 15:8) differs from the last page selected in the session, or when no page has been selected yet, two write commands are emitted first. The first carries the start flag and data byte 0x01. The second has no start flag and carries the new page value.
- R2: A write record whose address is not the expected next address emits a write command with the start flag and the low address byte. This happens after any page change, for the first write of a session, and for the first write after a delay record. The record's data byte then follows with no start flag.
- R3: A write record whose address equals the previous write's address plus one, on the same page, emits only its data byte with no start flag, extending the burst. A record with operation code 3 is accepted and discarded and does not break a burst. Operation codes are: 0 write, 1 delay, 2 end of list, 3 ignored.
- R4: Every command word has bits 6:0 equal to DEV_ADDR, bit 8 (read) at 0 and bit 10 (write-multiple) at 0. Bit 7 is start, bit 9 is write and bit 11 is stop. Every command with bit 9 set is issued together with exactly one data-channel byte.
- R5: A command or data beat that is not accepted keeps its valid and its value unchanged. No new beat is issued while an earlier beat still waits for its ready.
- R6: A delay record accepted while both output channels are empty holds record-ready low for exactly N+1 cycles. N is FAST_CYCLES when SIM_SPEEDUP is 1 and DELAY_CYCLES otherwise. The delay keeps the selected page but forgets the expected address.
- R7: An end-of-list record emits one command that has only the stop flag and the device address. Busy falls at the clock edge on which that command is accepted. While not busy, record-ready and both output valids stay low.
- R8: A start pulse while idle raises busy on the next cycle and clears page and address tracking. The first write of every session therefore gets a page select and an address write, even if the page is the one last used.
- R9: After reset, busy, record-ready, command valid and data valid are all low.
- R10: An address step that crosses a page boundary (for example 0x0BFF to 0x0C00) emits a page select followed by a fresh address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a session when idle |
| busy | output | 1 | High from session start until the stop command is taken |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Record accepted on this edge when valid |
| rec_op | input | 2 | 0 write, 1 delay, 2 end of list, 3 ignored |
| rec_addr | input | 16 | Register address (page in 15:8, offset in 7:0) |
| rec_data | input | 8 | Register value |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Command word taken |
| cmd_data | output | 12 | Device address and transfer flags |
| wr_valid | output | 1 | Write byte valid |
| wr_ready | input | 1 | Write byte taken |
| wr_data | output | 8 | Write byte |

## Verification
The first beat of a record is registered on the edge after the record is taken, provided both channels are free. Later beats follow one per cycle while the ready inputs stay high. Record-ready returns on the edge after the last beat is issued. Because beat timing moves with back-pressure, the bench captures every beat at its handshake and compares the sequences with a model built from the requirements, not with fixed cycle numbers. The two fixed latencies are checked cycle by cycle from falling-edge samples: the N+1 cycles of low record-ready after a delay, and busy falling on the edge that takes the stop command.

// File: rtl/prw_pkg.sv
package prw_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_DELAY = 2'd1,
    OP_END   = 2'd2,
    OP_NOP   = 2'd3
  } rec_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACC,
    S_PGREG,
    S_PGVAL,
    S_OFFS,
    S_DATA,
    S_WAIT,
    S_STOP,
    S_FIN
  } seq_state_e;

  localparam int          CMD_W        = 12;
  localparam logic [7:0]  PAGE_SEL_REG = 8'h01;

  function automatic logic [7:0] page_of(input logic [15:0] a);
    return a[15:8];
  endfunction

  function automatic logic [7:0] offs_of(input logic [15:0] a);
    return a[7:0];
  endfunction

  function automatic logic [15:0] next_addr(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  // [11] stop, [10] write-multiple, [9] write, [8] read, [7] start, [6:0] device
  function automatic logic [CMD_W-1:0] pack_cmd(input logic [6:0] dev,
                                                 input logic st,
                                                 input logic wr,
                                                 input logic sp);
    return {sp, 1'b0, wr, 1'b0, st, dev};
  endfunction

endpackage

// File: rtl/prw_track.sv
module prw_track import prw_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_all,
  input  logic        clr_exp,
  input  logic        upd,
  input  logic [15:0] addr,
  output logic        need_page,
  output logic        need_addr
);
  logic        page_ok_q, exp_ok_q;
  logic [7:0]  page_q;
  logic [15:0] exp_q;

  assign need_page = !page_ok_q || (page_q != page_of(addr));
  assign need_addr = !exp_ok_q  || (exp_q  != addr) || need_page;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      page_ok_q <= 1'b0;
      exp_ok_q  <= 1'b0;
      page_q    <= '0;
      exp_q     <= '0;
    end else if (upd) begin
      page_ok_q <= 1'b1;
      page_q    <= page_of(addr);
      exp_ok_q  <= 1'b1;
      exp_q     <= next_addr(addr);
    end else if (clr_exp) begin
      exp_ok_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/prw_delay.sv
module prw_delay #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(N);
    else if (tick && !done) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/prw_beat_out.sv
module prw_beat_out import prw_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             has_wr,
  input  logic [7:0]       wr_byte,
  input  logic             cmd_ready,
  input  logic             wr_ready,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  output logic             wr_valid,
  output logic [7:0]       wr_data,
  output logic             free,
  output logic             empty
);
  assign free  = (!cmd_valid || cmd_ready) && (!wr_valid || wr_ready);
  assign empty = !cmd_valid && !wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      cmd_data  <= '0;
      wr_data   <= '0;
    end else begin
      cmd_valid <= issue ? 1'b1   : (cmd_valid && !cmd_ready);
      wr_valid  <= issue ? has_wr : (wr_valid && !wr_ready);
      if (issue) cmd_data <= cmd_word;
      if (issue && has_wr) wr_data <= wr_byte;
    end
  end
endmodule

// File: rtl/paged_reg_writer.sv
module paged_reg_writer import prw_pkg::*; #(
  parameter logic [6:0] DEV_ADDR     = 7'h74,
  parameter int         DELAY_CYCLES = 30_000_000,
  parameter bit         SIM_SPEEDUP  = 1'b0,
  parameter int         FAST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [1:0]        rec_op,
  input  logic [15:0]       rec_addr,
  input  logic [7:0]        rec_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_data
);
  localparam int DLY_N = SIM_SPEEDUP ? FAST_CYCLES : DELAY_CYCLES;

  seq_state_e  st_q, st_d;
  logic [15:0] addr_q;
  logic [7:0]  data_q;

  // named internal events
  logic rec_take, take_write, take_delay, take_end, sess_open;
  logic need_page, need_addr;
  logic beat_go, beat_start, beat_stop, beat_has_wr;
  logic [7:0] beat_byte;
  logic out_free, out_empty;
  logic dly_active, dly_done;

  assign rec_ready  = (st_q == S_ACC);
  assign busy       = (st_q != S_IDLE);
  assign rec_take   = rec_valid && rec_ready;
  assign take_write = rec_take && (rec_op_e'(rec_op) == OP_WRITE);
  assign take_delay = rec_take && (rec_op_e'(rec_op) == OP_DELAY);
  assign take_end   = rec_take && (rec_op_e'(rec_op) == OP_END);
  assign sess_open  = (st_q == S_IDLE) && start;
  assign dly_active = (st_q == S_WAIT);

  prw_track u_track (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (sess_open),
    .clr_exp   (take_delay),
    .upd       (take_write),
    .addr      (rec_addr),
    .need_page (need_page),
    .need_addr (need_addr)
  );

  prw_delay #(.N(DLY_N)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .load (take_delay),
    .tick (dly_active && out_empty),
    .done (dly_done)
  );

  prw_beat_out u_out (
    .clk       (clk),
    .rst       (rst),
    .issue     (beat_go),
    .cmd_word  (pack_cmd(DEV_ADDR, beat_start, !beat_stop, beat_stop)),
    .has_wr    (beat_has_wr),
    .wr_byte   (beat_byte),
    .cmd_ready (cmd_ready),
    .wr_ready  (wr_ready),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .free      (out_free),
    .empty     (out_empty)
  );

  always_comb begin
    st_d        = st_q;
    beat_go     = 1'b0;
    beat_start  = 1'b0;
    beat_stop   = 1'b0;
    beat_has_wr = 1'b1;
    beat_byte   = '0;
    case (st_q)
      S_IDLE: if (start) st_d = S_ACC;
      S_ACC: begin
        if (take_write)      st_d = need_page ? S_PGREG : (need_addr ? S_OFFS : S_DATA);
        else if (take_delay) st_d = S_WAIT;
        else if (take_end)   st_d = S_STOP;
      end
      S_PGREG: if (out_free) begin
        beat_go    = 1'b1;
        beat_start = 1'b1;
        beat_byte  = PAGE_SEL_REG;
        st_d       = S_PGVAL;
      end
      S_PGVAL: if (out_free) begin
        beat_go   = 1'b1;
        beat_byte = page_of(addr_q);
        st_d      = S_OFFS;
      end
      S_OFFS: if (out_free) begin
        beat_go    = 1'b1;
        beat_start = 1'b1;
        beat_byte  = offs_of(addr_q);
        st_d       = S_DATA;
      end
      S_DATA: if (out_free) begin
        beat_go   = 1'b1;
        beat_byte = data_q;
        st_d      = S_ACC;
      end
      S_WAIT: if (dly_done) st_d = S_ACC;
      S_STOP: if (out_free) begin
        beat_go     = 1'b1;
        beat_stop   = 1'b1;
        beat_has_wr = 1'b0;
        st_d        = S_FIN;
      end
      S_FIN: if (out_free) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_write) begin
        addr_q <= rec_addr;
        data_q <= rec_data;
      end
    end
  end
endmodule

// File: rtl/prw_chk.sv
module prw_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h74
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic [1:0]  rec_op,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [11:0] cmd_data,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [7:0]  wr_data
);
  p_fields_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_data[6:0] == DEV_ADDR) && !cmd_data[8] && !cmd_data[10]);

  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  p_delay_block_r6: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_ready && (rec_op == 2'd1) |=> !rec_ready);

  p_stop_only_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_data[11] |-> !cmd_data[9] && !cmd_data[7]);

  p_end_busy_r7: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_ready && (rec_op == 2'd2) |=> busy);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rec_ready && !cmd_valid && !wr_valid);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> busy);
endmodule

bind paged_reg_writer prw_chk #(.DEV_ADDR(DEV_ADDR)) u_prw_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_op    (rec_op),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data)
);

// File: tb/tb_paged_reg_writer.sv
`timescale 1ns/1ps
module tb_paged_reg_writer;
  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] DEV        = 7'h74;
  localparam int         DLYN       = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [1:0]  rec_op = '0;
  logic [15:0] rec_addr = '0;
  logic [7:0]  rec_data = '0;
  logic        cmd_valid, wr_valid;
  logic        cmd_ready = 1'b1, wr_ready = 1'b1;
  logic [11:0] cmd_data;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit stop_pending = 1'b0;

  logic [11:0] got_cmd[$], exp_cmd[$];
  logic [7:0]  got_wr[$],  exp_wr[$];
  bit          m_pg_ok, m_ex_ok;
  logic [7:0]  m_pg;
  logic [15:0] m_ex;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_reg_writer #(.DEV_ADDR(DEV), .SIM_SPEEDUP(1'b1), .FAST_CYCLES(DLYN)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_op(rec_op),
    .rec_addr(rec_addr), .rec_data(rec_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ready driver and handshake monitor, all at the falling edge
  always @(negedge clk) begin
    if (stop_pending) begin
      stop_pending = 1'b0;
      check(!busy, "R7", "busy after stop taken", int'(busy), 0);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = bp_mode ? lfsr[0] : 1'b1;
    wr_ready  = bp_mode ? lfsr[2] : 1'b1;
    if (!rst) begin
      if (cmd_valid && cmd_ready) begin
        got_cmd.push_back(cmd_data);
        if (cmd_data[11]) stop_pending = 1'b1;
      end
      if (wr_valid && wr_ready) got_wr.push_back(wr_data);
    end
  end

  // model built from R1..R3, R6, R8, R10
  task automatic m_byte(input bit st, input logic [7:0] b);
    exp_cmd.push_back({1'b0, 1'b0, 1'b1, 1'b0, st, DEV});
    exp_wr.push_back(b);
  endtask

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    if (!m_pg_ok || m_pg != a[15:8]) begin
      m_byte(1'b1, 8'h01);
      m_byte(1'b0, a[15:8]);
      m_pg = a[15:8]; m_pg_ok = 1'b1; m_ex_ok = 1'b0;
    end
    if (!m_ex_ok || m_ex != a) m_byte(1'b1, a[7:0]);
    m_byte(1'b0, d);
    m_ex = a + 16'd1; m_ex_ok = 1'b1;
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    rec_valid = 1'b1; rec_op = op; rec_addr = a; rec_data = d;
    while (!rec_ready) @(negedge clk);
    @(posedge clk);
    #1 rec_valid = 1'b0;
    if (op == 2'd0) m_write(a, d);
    if (op == 2'd1) m_ex_ok = 1'b0;
    if (op == 2'd2) exp_cmd.push_back({1'b1, 4'b0000, DEV});
  endtask

  task automatic open_session(input string req);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    check(busy, req, "busy after start", int'(busy), 1);
    m_pg_ok = 1'b0; m_ex_ok = 1'b0;
    got_cmd.delete(); exp_cmd.delete(); got_wr.delete(); exp_wr.delete();
  endtask

  task automatic close_and_compare(input string req);
    send(2'd2, 16'h0, 8'h0);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!busy && !rec_ready, req, "idle after end", int'({busy, rec_ready}), 0);
    check(got_cmd.size() == exp_cmd.size(), req, "command count", got_cmd.size(), exp_cmd.size());
    check(got_wr.size() == exp_wr.size(), req, "data count", got_wr.size(), exp_wr.size());
    for (int i = 0; i < got_cmd.size() && i < exp_cmd.size(); i++)
      check(got_cmd[i] == exp_cmd[i], req, $sformatf("command %0d", i), got_cmd[i], exp_cmd[i]);
    for (int i = 0; i < got_wr.size() && i < exp_wr.size(); i++)
      check(got_wr[i] == exp_wr[i], req, $sformatf("byte %0d", i), got_wr[i], exp_wr[i]);
  endtask

  task automatic t_reset_r9();
    check(!busy && !rec_ready && !cmd_valid && !wr_valid, "R9", "reset outputs",
          int'({busy, rec_ready, cmd_valid, wr_valid}), 0);
  endtask

  // R1 R2 R3 R4: preamble pair forms one burst, op 3 leaves it intact
  task automatic t_burst();
    open_session("R8");
    send(2'd0, 16'h0B24, 8'hC0);
    send(2'd3, 16'h1234, 8'h55);
    send(2'd0, 16'h0B25, 8'h00);
    send(2'd0, 16'h0B26, 8'h7E);
    close_and_compare("R3");
  endtask

  // R2: same page, address jump reopens the transfer without page select
  task automatic t_jump();
    open_session("R8");
    send(2'd0, 16'h0B24, 8'h11);
    send(2'd0, 16'h0B4E, 8'h1A);
    send(2'd0, 16'h0957, 8'h17);
    close_and_compare("R2");
  endtask

  // R6: delay timing and forgotten address
  task automatic t_delay_r6();
    int lowc;
    open_session("R8");
    send(2'd0, 16'h0B25, 8'h00);
    repeat (8) @(negedge clk);
    send(2'd1, 16'h0, 8'h0);
    lowc = 0;
    @(negedge clk);
    while (!rec_ready && lowc < 1000) begin lowc++; @(negedge clk); end
    check(lowc == DLYN + 1, "R6", "ready-low cycles after delay", lowc, DLYN + 1);
    send(2'd0, 16'h0B26, 8'h44);
    close_and_compare("R6");
  endtask

  // R10: page boundary crossing
  task automatic t_wrap_r10();
    open_session("R8");
    send(2'd0, 16'h0BFF, 8'h01);
    send(2'd0, 16'h0C00, 8'h02);
    close_and_compare("R10");
  endtask

  // R5 R8: back-pressure; new session repeats the page select for page 0x0B
  task automatic t_backpressure_r5();
    bp_mode = 1'b1;
    open_session("R8");
    send(2'd0, 16'h001C, 8'h01);
    send(2'd0, 16'h0B24, 8'hC3);
    send(2'd0, 16'h0B25, 8'h02);
    close_and_compare("R5");
    open_session("R8");
    send(2'd0, 16'h0B26, 8'h99);
    close_and_compare("R8");
    bp_mode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r9();
    t_burst();
    t_jump();
    t_delay_r6();
    t_wrap_r10();
    t_backpressure_r5();
    // R7: after the last session the block stays quiet
    repeat (5) @(negedge clk);
    check(!cmd_valid && !wr_valid && !rec_ready, "R7", "quiet when idle",
          int'({cmd_valid, wr_valid, rec_ready}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule